// File: doc/BRIEF.md
# Speculative Shared Functional Unit

This block lets two elastic input channels, A and B, share a single functional unit whose result goes to an elastic two-way multiplexer. A third elastic channel carries the multiplexer's select token: 0 picks channel A and 1 picks channel B. The select is assumed to arrive late in the cycle. For that reason a scheduler does not wait for it. It guesses the select value, feeds the guessed channel into the shared unit, and holds the other channel with its stop signal.

When the guess matches the select, the select token and the chosen channel's token are consumed together. The result is registered into a one-entry output buffer. A wrong guess consumes nothing. The following cycle is a correction cycle: the unit runs on the channel the select actually named. The guess comes from the top bit of a saturating counter, which learns from every consumed select value. With a strongly skewed select stream, results stream back to back and only the rare outcomes pay one extra cycle.

Each select token consumes exactly one token, from the channel it names. The unselected channel keeps its token. The output stream is therefore identical to an unshared multiplexer that applies the function to the selected channel's stream in order.

Top module: `spec_share_unit`

## Requirements
- R1: After reset the output buffer is empty (`out_valid` = 0), the counter is zero (guess = channel A), and with no input tokens all three input stops are high.
- R2: In every cycle at most one of `a_stop` and `b_stop` is low. The channel that is not being executed always has its stop high.
- R3: If the select is valid, equals the executed channel, that channel is valid, and the output buffer can accept a result, then `sel_stop` and the executed channel's stop are low in that cycle. The result is then valid on the output in the next cycle.
- R4: On a misprediction (select valid, differs from the guess, no correction pending), no token is consumed and `sel_stop` stays high. The next cycle executes the channel named by the select.
- R5: A pending correction keeps executing the corrected channel until its transfer completes, including across output back-pressure.
- R6: The predictor is a CNT_W-bit saturating counter. It increments on each consumed select of 1 (channel B) and decrements on each consumed select of 0 (channel A). The guess is its top bit, so from a saturated state two opposite selects are needed to flip the guess.
- R7: While `out_valid` is high and `out_stop` is high, `out_valid` stays high and `out_data` is unchanged.
- R8: With correct guesses, all tokens present and no back-pressure, one select is consumed every cycle and results leave on consecutive cycles.
- R9: The result equals the input data rotated left by ROT bits and XORed with KEY (defaults: ROT = 1, KEY = 8'h5A).
- R10: For any select pattern, guess history, input valid gaps or output stalls, the output sequence equals that of an unshared multiplexer applying the function to the selected channel in order.
- R11: A select is not consumed while the channel it names has no token, and no channel token is consumed without a select token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Channel A token present |
| a_data | input | DW | Channel A data |
| a_stop | output | 1 | Hold channel A token |
| b_valid | input | 1 | Channel B token present |
| b_data | input | DW | Channel B data |
| b_stop | output | 1 | Hold channel B token |
| sel_valid | input | 1 | Select token present |
| sel | input | 1 | Select value: 0 = A, 1 = B |
| sel_stop | output | 1 | Hold select token |
| out_valid | output | 1 | Result token present |
| out_data | output | DW | Result data |
| out_stop | input | 1 | Downstream holds result |

## Verification
A misprediction and output back-pressure can land in the same cycle. In that case the correction must be recorded while the output buffer is full. It must then stay pending through further stalled cycles, without consuming the select or the channel token. The bench provokes this by stalling a freshly loaded result with `out_stop` while presenting a select that disagrees with the guess. It then checks the stops in each cycle and the corrected result after the stall is released. The table-driven run repeats such overlaps, with valid gaps, and compares the output sequence against an in-order unshared reference.

// File: rtl/spec_share_pkg.sv
package spec_share_pkg;

    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } ch_e;

    typedef struct packed {
        logic corr;
        ch_e  corr_ch;
    } sched_t;

endpackage

// File: rtl/spec_share_pred.sv
module spec_share_pred
    import spec_share_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  ch_e  upd_ch,
    output ch_e  guess
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MIN = '0;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (upd) begin
            if (upd_ch == CH_B) begin
                if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
            end else begin
                if (cnt_q != CNT_MIN) cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= CNT_MIN;
        else        cnt_q <= cnt_d;
    end

    assign guess = ch_e'(cnt_q[CNT_W-1]);

endmodule

// File: rtl/spec_share_sched.sv
module spec_share_sched
    import spec_share_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ch_e  guess,
    input  logic sel_valid,
    input  logic sel,
    input  logic a_valid,
    input  logic b_valid,
    input  logic out_ready,
    output ch_e  exec_ch,
    output logic fire,
    output logic miss
);
    sched_t st_d, st_q;
    logic   ch_ok;
    logic   hit;

    always_comb begin
        exec_ch = st_q.corr ? st_q.corr_ch : guess;
        ch_ok   = (exec_ch == CH_B) ? b_valid : a_valid;
        hit     = sel_valid && (ch_e'(sel) == exec_ch);
        fire    = hit && ch_ok && out_ready;
        miss    = sel_valid && (ch_e'(sel) != exec_ch) && !st_q.corr;

        st_d = st_q;
        if (fire) begin
            st_d.corr = 1'b0;
        end else if (miss) begin
            st_d.corr    = 1'b1;
            st_d.corr_ch = ch_e'(sel);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.corr    <= 1'b0;
            st_q.corr_ch <= CH_A;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/spec_share_fn.sv
module spec_share_fn #(
    parameter int          DW  = 8,
    parameter int          ROT = 1,
    parameter logic [DW-1:0] KEY = 8'h5A
) (
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int SHIFT = ROT % DW;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        localparam int SRC = (i - SHIFT + DW) % DW;
        assign dout[i] = din[SRC] ^ KEY[i];
    end

endmodule

// File: rtl/spec_share_obuf.sv
module spec_share_obuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          out_stop,
    output logic          ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] dat;
    } obuf_t;

    obuf_t ob_d, ob_q;

    always_comb begin
        ready = !ob_q.vld || !out_stop;
        ob_d  = ob_q;
        if (load) begin
            ob_d.vld = 1'b1;
            ob_d.dat = din;
        end else if (ob_q.vld && !out_stop) begin
            ob_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ob_q.vld <= 1'b0;
            ob_q.dat <= '0;
        end else begin
            ob_q <= ob_d;
        end
    end

    assign out_valid = ob_q.vld;
    assign out_data  = ob_q.dat;

endmodule

// File: rtl/spec_share_unit.sv
module spec_share_unit
    import spec_share_pkg::*;
#(
    parameter int            DW    = 8,
    parameter int            CNT_W = 2,
    parameter int            ROT   = 1,
    parameter logic [DW-1:0] KEY   = 8'h5A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_valid,
    input  logic [DW-1:0] a_data,
    output logic          a_stop,
    input  logic          b_valid,
    input  logic [DW-1:0] b_data,
    output logic          b_stop,
    input  logic          sel_valid,
    input  logic          sel,
    output logic          sel_stop,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    input  logic          out_stop
);
    ch_e           guess;
    ch_e           exec_ch;
    logic          fire;
    logic          miss;
    logic          out_ready;
    logic [DW-1:0] fn_in;
    logic [DW-1:0] fn_out;

    spec_share_pred #(.CNT_W(CNT_W)) pred_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (fire),
        .upd_ch (ch_e'(sel)),
        .guess  (guess)
    );

    spec_share_sched sched_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .guess     (guess),
        .sel_valid (sel_valid),
        .sel       (sel),
        .a_valid   (a_valid),
        .b_valid   (b_valid),
        .out_ready (out_ready),
        .exec_ch   (exec_ch),
        .fire      (fire),
        .miss      (miss)
    );

    assign fn_in = (exec_ch == CH_B) ? b_data : a_data;

    spec_share_fn #(.DW(DW), .ROT(ROT), .KEY(KEY)) fn_i (
        .din  (fn_in),
        .dout (fn_out)
    );

    spec_share_obuf #(.DW(DW)) obuf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (fire),
        .din       (fn_out),
        .out_stop  (out_stop),
        .ready     (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    assign a_stop   = !(fire && exec_ch == CH_A);
    assign b_stop   = !(fire && exec_ch == CH_B);
    assign sel_stop = !fire;

endmodule

// File: rtl/spec_share_chk.sv
module spec_share_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          a_stop,
    input logic          b_stop,
    input logic          sel_valid,
    input logic          sel,
    input logic          sel_stop,
    input logic          out_valid,
    input logic [DW-1:0] out_data,
    input logic          out_stop,
    input logic          exec_bit
);
    p_one_chan_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !a_stop |-> b_stop);

    p_sel_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && !sel_stop) |-> (sel ? !b_stop : !a_stop));

    p_result_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && !sel_stop) |=> out_valid);

    p_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_stop && (exec_bit != sel)) |=> (exec_bit == $past(sel)));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_stop) |=> (out_valid && $stable(out_data)));

    p_no_lone_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_stop || !b_stop) |-> (sel_valid && !sel_stop));

endmodule

bind spec_share_unit spec_share_chk #(.DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_stop    (a_stop),
    .b_stop    (b_stop),
    .sel_valid (sel_valid),
    .sel       (sel),
    .sel_stop  (sel_stop),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_stop  (out_stop),
    .exec_bit  (exec_ch)
);

// File: tb/spec_share_unit_tb_top.sv
`timescale 1ns/1ps
module spec_share_unit_tb_top;
    localparam int DW    = 8;
    localparam int NV    = 24;
    localparam int WDOG  = 100000;

    // entry = {sel, out_stop}
    localparam logic [1:0] VEC [NV] = '{
        2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 2'b01, 2'b00, 2'b00,
        2'b11, 2'b10, 2'b10, 2'b00, 2'b01, 2'b00, 2'b10, 2'b00,
        2'b00, 2'b01, 2'b00, 2'b00, 2'b10, 2'b11, 2'b00, 2'b00
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_valid = 1'b0, b_valid = 1'b0, sel_valid = 1'b0, sel = 1'b0, out_stop = 1'b0;
    logic [DW-1:0] a_data = '0, b_data = '0;
    logic          a_stop, b_stop, sel_stop, out_valid;
    logic [DW-1:0] out_data;

    logic          s_as, s_bs, s_ss, s_ov;
    logic [DW-1:0] s_od;

    int n_run = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    spec_share_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_valid(a_valid), .a_data(a_data), .a_stop(a_stop),
        .b_valid(b_valid), .b_data(b_data), .b_stop(b_stop),
        .sel_valid(sel_valid), .sel(sel), .sel_stop(sel_stop),
        .out_valid(out_valid), .out_data(out_data), .out_stop(out_stop)
    );

    function automatic logic [DW-1:0] ref_fn(input logic [DW-1:0] x);
        return {x[DW-2:0], x[DW-1]} ^ 8'h5A;
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic sv, input logic s, input logic av, input logic bv, input logic os);
        @(negedge clk);
        sel_valid = sv; sel = s; a_valid = av; b_valid = bv; out_stop = os;
        #1;
        s_as = a_stop; s_bs = b_stop; s_ss = sel_stop; s_ov = out_valid; s_od = out_data;
        @(posedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sel_valid = 0; a_valid = 0; b_valid = 0; out_stop = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG && !done) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG);
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        int outs;
        do_reset();

        // R1: reset state
        step(0, 0, 0, 0, 0);
        chk(s_ov == 1'b0, "R1 out_valid after reset", s_ov, 0);
        chk(s_as && s_bs && s_ss, "R1 stops high idle", {s_as, s_bs, s_ss}, 3'b111);

        // R4/R5: first B select mispredicted (guess A)
        b_data = 8'h33;
        step(1, 1, 1, 1, 0);
        chk(s_ss && s_bs && s_as, "R4 miss consumes nothing", {s_as, s_bs, s_ss}, 3'b111);
        step(1, 1, 1, 1, 0);
        chk(!s_ss && !s_bs && s_as, "R4 correction on B", {s_as, s_bs, s_ss}, 3'b100);
        step(0, 0, 1, 1, 0);
        chk(s_ov == 1'b1, "R3 result next cycle", s_ov, 1);
        chk(s_od == ref_fn(8'h33), "R9 function B", s_od, ref_fn(8'h33));

        // R6: second B still mispredicts, third fires at once
        step(1, 1, 1, 1, 0);
        chk(s_ss == 1'b1, "R6 second B mispredicts", s_ss, 1);
        step(1, 1, 1, 1, 0);
        chk(s_ss == 1'b0, "R5 second correction", s_ss, 0);
        step(1, 1, 1, 1, 0);
        chk(s_ss == 1'b0 && s_bs == 1'b0, "R6 third B guessed", {s_bs, s_ss}, 0);

        // R6 hysteresis: counter at 3, two A selects needed
        a_data = 8'h44;
        step(1, 0, 1, 1, 0);
        chk(s_ss && s_as, "R6 A miss from saturated", {s_as, s_ss}, 3);
        step(1, 0, 1, 1, 0);
        chk(!s_as && s_bs, "R2 correction on A only", {s_as, s_bs}, 1);
        step(1, 0, 1, 1, 0);
        chk(s_ss == 1'b1, "R6 guess still B", s_ss, 1);
        step(1, 0, 1, 1, 0);
        chk(s_ss == 1'b0, "R6 correction A", s_ss, 0);
        step(1, 0, 1, 1, 0);
        chk(s_ss == 1'b0, "R6 guess flipped to A", s_ss, 0);

        // R11: selected channel empty
        step(1, 0, 0, 1, 0);
        chk(s_ss && s_as && s_bs, "R11 no take without token", {s_as, s_bs, s_ss}, 3'b111);
        a_data = 8'h81;
        step(1, 0, 1, 1, 0);
        chk(!s_ss && !s_as, "R11 take once valid", {s_as, s_ss}, 0);

        // R7: hold under back-pressure
        step(1, 0, 1, 1, 1);
        chk(s_ov && s_od == ref_fn(8'h81), "R7 stalled data", s_od, ref_fn(8'h81));
        chk(s_ss == 1'b1, "R7 no fire when full", s_ss, 1);
        step(1, 0, 1, 1, 1);
        chk(s_ov && s_od == ref_fn(8'h81), "R7 data stable", s_od, ref_fn(8'h81));
        step(0, 0, 1, 1, 0);

        // R8: back-to-back
        outs = 0;
        for (int i = 0; i < 6; i++) begin
            step(1, 0, 1, 1, 0);
            chk(s_ss == 1'b0, "R8 select each cycle", s_ss, 0);
            if (i > 0 && s_ov) outs++;
        end
        step(0, 0, 1, 1, 0);
        if (s_ov) outs++;
        chk(outs == 6, "R8 consecutive results", outs, 6);

        // R5 combined with back-pressure
        a_data = 8'h12; b_data = 8'h9C;
        step(1, 0, 1, 1, 0);
        step(1, 1, 1, 1, 1);
        chk(s_ss && s_bs, "R4 miss while stalled", {s_bs, s_ss}, 3);
        step(1, 1, 1, 1, 1);
        chk(s_ss && s_bs && s_as, "R5 correction waits", {s_as, s_bs, s_ss}, 3'b111);
        step(1, 1, 1, 1, 0);
        chk(!s_bs && !s_ss, "R5 correction completes", {s_bs, s_ss}, 0);
        step(0, 0, 1, 1, 0);
        chk(s_ov && s_od == ref_fn(8'h9C), "R5 corrected result", s_od, ref_fn(8'h9C));

        // R10: table run against unshared reference
        do_reset();
        begin
            logic [DW-1:0] expq [NV];
            int na = 0, nb = 0, ia = 0, ib = 0, si = 0, ko = 0, t = 0;
            for (int k = 0; k < NV; k++) begin
                if (VEC[k][1]) begin expq[k] = ref_fn(8'hA0 + DW'(nb)); nb++; end
                else           begin expq[k] = ref_fn(8'h10 + DW'(na)); na++; end
            end
            while (ko < NV && t < 2000) begin
                @(negedge clk);
                sel_valid = (si < NV);
                sel       = (si < NV) ? VEC[si][1] : 1'b0;
                a_valid   = (t % 5) != 3;
                b_valid   = (t % 7) != 2;
                a_data    = 8'h10 + DW'(ia);
                b_data    = 8'hA0 + DW'(ib);
                out_stop  = VEC[t % NV][0];
                #1;
                if (out_valid && !out_stop) begin
                    chk(out_data == expq[ko], "R10 sequence", out_data, expq[ko]);
                    ko++;
                end
                if (sel_valid && !sel_stop) si++;
                if (a_valid && !a_stop) ia++;
                if (b_valid && !b_stop) ib++;
                @(posedge clk);
                t++;
            end
            chk(ko == NV, "R10 all results seen", ko, NV);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule